// File: doc/BRIEF.md
# Mains-Clocked BCD Calendar Counter

This block keeps time of day and calendar date from a slow digital clock at mains frequency (50 Hz or 60 Hz) instead of a crystal. The slow input is brought into the system clock domain through a synchronizer. Its rising edges are counted by a prescaler that divides by 50 or 60 at run time, and the resulting one-second tick advances a chain of BCD counters: seconds, minutes, hours in 24-hour form, day of week, day of month, month, year, and a two-bit binary century field. Month lengths and the leap-year rule, including the century-dependent rule for year 00, are applied automatically.

The counters form an internal working copy. A second, user-visible copy of the eight time registers is refreshed from it as a whole on every system clock while the hold input is low. A host reading the time raises hold, so the bytes it reads stay consistent, while the working copy keeps counting. A host write port loads any time register. Every such write also restarts the prescaler, so the next second falls a full divide period after the write. A gated 1 Hz square wave and an open-drain select bit for its pad are also provided.

Top module: `mains_rtc_core`

## Requirements
- R1: The seconds field advances once per 60 rising edges of `line_clk_i` when the frequency select bit (bit 7 of register 5) is 1, and once per 50 edges when it is 0. The select bit resets to 1.
- R2: Seconds (register 1, bits 6:0) and minutes (register 2, bits 6:0) count BCD 00-59, and hours (register 3, bits 5:0) count BCD 00-23. Each field carries into the next when it wraps to 00.
- R3: Day of week (register 4, bits 2:0) holds 1-7. It advances only when the hours wrap at midnight, and it wraps from 7 to 1.
- R4: Day of month (register 5, bits 5:0, BCD) wraps to 01 and advances the month after the last day of the month. That last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11.
- R5: February has 29 days when the BCD year is divisible by 4, and 28 days otherwise. For year 00 the rule is narrower: February has 29 days only when the century field is 0.
- R6: Month (register 6, bits 4:0, BCD) wraps from 12 to 01 and advances the year (register 7, BCD 00-99). When the year wraps from 99 to 00, the century field (register 6, bits 7:6) increments in binary and wraps from 3 to 0.
- R7: When the halt bit (register 1, bit 7) is 1, no time field changes. The bit resets to 0. Once it is cleared, counting resumes one full divide period later.
- R8: A write to any register address 0-7 loads that register. The write also clears the prescaler, so the next second comes exactly one divide period of input edges after the write. A write to address 0 stores nothing.
- R9: `usr_regs_o` byte k shows time register k. Byte 0 always reads 0. While `hold_i` is high the bytes stay frozen while internal counting goes on. After `hold_i` falls, the current time appears.
- R10: When the enable bit (register 0xA, bit 6) is 1, `sqw_o` is high while fewer than half the divide period's edges have been counted in the current second, and low for the rest. When the bit is 0, `sqw_o` is low. The bit resets to 0.
- R11: `sqw_od_o` follows bit 6 of the last write to register 0xC and resets to 0.
- R12: After reset, the time reads 00:00:00, day of week 1, date 01, month 01, year 00, century 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_clk_i | input | 1 | 50/60 Hz digital time base, asynchronous |
| hold_i | input | 1 | Freezes the user-visible copy while high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Register write data |
| usr_regs_o | output | 64 | User copy of time registers 0-7, byte k at bits 8k+7:8k |
| sqw_o | output | 1 | Gated 1 Hz square wave |
| sqw_od_o | output | 1 | Open-drain select for the square-wave pad |

## Verification
The bench sweeps every month across years chosen to cover each leap-year case: divisible by 4, not divisible, and year 00 with century 0 and with non-zero centuries. For each, it lands once on the expected last day and once on the day before. A table that is too short shows up as an early wrap, and one that is too long shows up as a missing rollover into the next month. Boundary carries are exercised at midnight with day-of-week 7, at a BCD digit carry at minute 09, at the year 99 wrap and at the century 3 wrap; a wrong carry leaves a stale or binary-incremented field. A write in mid-second must restart the prescaler: if it does not, the next second comes early. A hold window must freeze the visible bytes while the internal copy still counts, so a design that froze the counter would lose a second after the hold is released.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int REG_CNT = 8;
  localparam int REG_W   = 8;

  typedef struct packed {
    logic       halt;
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [2:0] dow;
    logic       sel60;
    logic [5:0] date;
    logic [1:0] cent;
    logic [4:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  // Two-digit BCD increment without range check.
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // Leap rule: BCD year divisible by 4; year 00 only for century 0.
  function automatic logic is_leap(input logic [7:0] yr, input logic [1:0] c);
    logic div4;
    if (yr[4]) div4 = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       div4 = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    if (yr == 8'h00) return (c == 2'd0);
    return div4;
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [REG_CNT*REG_W-1:0] pack_regs(input rtc_time_t t);
    return {t.year,
            t.cent, 1'b0, t.mon,
            t.sel60, 1'b0, t.date,
            5'b0, t.dow,
            2'b0, t.hour,
            1'b0, t.min,
            t.halt, t.sec,
            8'h00};
  endfunction

endpackage

// File: rtl/rtc_line_prescaler.sv
module rtc_line_prescaler #(
  parameter int DIV_LO      = 50,
  parameter int DIV_HI      = 60,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic sel_hi_i,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o,
  output logic half_o
);

  localparam int CW = $clog2(DIV_HI);

  logic [SYNC_STAGES:0] sync_q, sync_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [CW-1:0]        lim, half;
  logic                 rise;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-1:0], line_i};
    rise   = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    lim    = sel_hi_i ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
    half   = sel_hi_i ? CW'(DIV_HI / 2) : CW'(DIV_LO / 2);
    tick_o = rise & run_i & ~clr_i & (cnt_q == lim);
    half_o = (cnt_q < half);
    cnt_d  = cnt_q;
    if (clr_i || !run_i)  cnt_d = '0;
    else if (rise)        cnt_d = (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);

  // R8
  clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_cal_chain.sv
module rtc_cal_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output rtc_time_t  time_o
);

  rtc_time_t cur_q, nxt;
  logic       leap;
  logic [5:0] last_day;
  logic       adv;

  always_comb begin
    leap     = is_leap(cur_q.year, cur_q.cent);
    last_day = month_last(cur_q.mon, leap);
    adv      = tick_i & ~cur_q.halt & ~wr_i;
    nxt      = cur_q;
    if (wr_i) begin
      case (wr_addr_i)
        3'd1: begin nxt.halt = wr_data_i[7]; nxt.sec = wr_data_i[6:0]; end
        3'd2: nxt.min = wr_data_i[6:0];
        3'd3: nxt.hour = wr_data_i[5:0];
        3'd4: nxt.dow = wr_data_i[2:0];
        3'd5: begin nxt.sel60 = wr_data_i[7]; nxt.date = wr_data_i[5:0]; end
        3'd6: begin nxt.cent = wr_data_i[7:6]; nxt.mon = wr_data_i[4:0]; end
        3'd7: nxt.year = wr_data_i;
        default: ;
      endcase
    end else if (adv) begin
      if (cur_q.sec < 7'h59) begin
        nxt.sec = 7'(bcd_inc8({1'b0, cur_q.sec}));
      end else begin
        nxt.sec = '0;
        if (cur_q.min < 7'h59) begin
          nxt.min = 7'(bcd_inc8({1'b0, cur_q.min}));
        end else begin
          nxt.min = '0;
          if (cur_q.hour < 6'h23) begin
            nxt.hour = 6'(bcd_inc8({2'b0, cur_q.hour}));
          end else begin
            nxt.hour = '0;
            nxt.dow  = (cur_q.dow >= 3'd7 || cur_q.dow == 3'd0) ? 3'd1 : cur_q.dow + 3'd1;
            if (cur_q.date < last_day) begin
              nxt.date = 6'(bcd_inc8({2'b0, cur_q.date}));
            end else begin
              nxt.date = 6'h01;
              if (cur_q.mon < 5'h12) begin
                nxt.mon = 5'(bcd_inc8({3'b0, cur_q.mon}));
              end else begin
                nxt.mon = 5'h01;
                if (cur_q.year < 8'h99) begin
                  nxt.year = bcd_inc8(cur_q.year);
                end else begin
                  nxt.year = 8'h00;
                  nxt.cent = cur_q.cent + 2'd1;
                end
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q.halt  <= 1'b0;
      cur_q.sec   <= '0;
      cur_q.min   <= '0;
      cur_q.hour  <= '0;
      cur_q.dow   <= 3'd1;
      cur_q.sel60 <= 1'b1;
      cur_q.date  <= 6'h01;
      cur_q.cent  <= '0;
      cur_q.mon   <= 5'h01;
      cur_q.year  <= '0;
    end else begin
      cur_q <= nxt;
    end
  end

  assign time_o = cur_q;

  // R7
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q.halt && !wr_i) |=> $stable(cur_q));

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cur_q.sec == 7'h59) |=> (cur_q.sec == 7'h00 && cur_q.min != $past(cur_q.min)));

  // R6
  cent_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q.year == 8'h00 && $past(cur_q.year) == 8'h99 && !$past(wr_i))
      |-> (cur_q.cent == 2'($past(cur_q.cent) + 2'd1)));

endmodule

// File: rtl/rtc_user_copy.sv
module rtc_user_copy #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] usr_o
);

  logic [W-1:0] usr_q, usr_d;
  logic         load_en;

  always_comb begin
    load_en = ~hold_i;
    usr_d   = load_en ? src_i : usr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) usr_q <= '0;
    else        usr_q <= usr_d;
  end

  assign usr_o = usr_q;

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(usr_q));

endmodule

// File: rtl/rtc_sqw_out.sv
module rtc_sqw_out #(
  parameter logic [3:0] EN_ADDR = 4'hA,
  parameter logic [3:0] OD_ADDR = 4'hC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr_i,
  input  logic [3:0] cfg_addr_i,
  input  logic       cfg_bit_i,
  input  logic       half_i,
  output logic       sqw_o,
  output logic       od_o
);

  logic en_q, en_d, od_q, od_d, sqw_q, sqw_d;

  always_comb begin
    en_d  = (cfg_wr_i && cfg_addr_i == EN_ADDR) ? cfg_bit_i : en_q;
    od_d  = (cfg_wr_i && cfg_addr_i == OD_ADDR) ? cfg_bit_i : od_q;
    sqw_d = en_q & half_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      od_q  <= 1'b0;
      sqw_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      od_q  <= od_d;
      sqw_q <= sqw_d;
    end
  end

  assign sqw_o = sqw_q;
  assign od_o  = od_q;

  // R10
  sqw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_o |-> $past(en_q));

  // R11
  od_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && cfg_addr_i == OD_ADDR) |=> (od_o == $past(cfg_bit_i)));

endmodule

// File: rtl/mains_rtc_core.sv
module mains_rtc_core
  import rtc_pkg::*;
#(
  parameter int DIV_LO      = 50,
  parameter int DIV_HI      = 60,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     line_clk_i,
  input  logic                     hold_i,
  input  logic                     wr_en_i,
  input  logic [3:0]               wr_addr_i,
  input  logic [7:0]               wr_data_i,
  output logic [REG_CNT*REG_W-1:0] usr_regs_o,
  output logic                     sqw_o,
  output logic                     sqw_od_o
);

  localparam int RW = REG_CNT * REG_W;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic                  time_wr, tick, half;
  rtc_time_t             work;
  logic [RW-1:0]         packed_regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  assign time_wr     = wr_en_i & ~wr_addr_i[3];
  assign packed_regs = pack_regs(work);

  rtc_line_prescaler #(
    .DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .SYNC_STAGES(SYNC_STAGES)
  ) u_pre (
    .clk(clk), .rst_n(rst_int_n), .line_i(line_clk_i), .sel_hi_i(work.sel60),
    .run_i(~work.halt), .clr_i(time_wr), .tick_o(tick), .half_o(half)
  );

  rtc_cal_chain u_cal (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick), .wr_i(time_wr),
    .wr_addr_i(wr_addr_i[2:0]), .wr_data_i(wr_data_i), .time_o(work)
  );

  rtc_user_copy #(.W(RW)) u_usr (
    .clk(clk), .rst_n(rst_int_n), .hold_i(hold_i), .src_i(packed_regs), .usr_o(usr_regs_o)
  );

  rtc_sqw_out u_sqw (
    .clk(clk), .rst_n(rst_int_n), .cfg_wr_i(wr_en_i), .cfg_addr_i(wr_addr_i),
    .cfg_bit_i(wr_data_i[6]), .half_i(half), .sqw_o(sqw_o), .od_o(sqw_od_o)
  );

endmodule

// File: tb/tb_mains_rtc_core.sv
module tb_mains_rtc_core;

  logic        clk = 1'b0;
  logic        rst_n, line, hold, wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [63:0] usr;
  logic        sqw, sqw_od;
  int          checks = 0;
  int          fails  = 0;

  always #4 clk = ~clk;

  mains_rtc_core dut (
    .clk(clk), .rst_n(rst_n), .line_clk_i(line), .hold_i(hold),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .usr_regs_o(usr), .sqw_o(sqw), .sqw_od_o(sqw_od)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] rb(input int k);
    return usr[8*k +: 8];
  endfunction

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int dim(input int m, input int y, input int c);
    if (m == 2) return ((y % 4 == 0) && (y != 0 || c == 0)) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      line = 1'b1; repeat (4) @(negedge clk);
      line = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic set_time(input int c, input int yr, input int mo, input int dt,
                          input int dw, input int hr, input int mi, input int sc);
    logic [7:0] mb;
    mb = bcd(mo);
    wr(4'd1, bcd(sc));
    wr(4'd2, bcd(mi));
    wr(4'd3, bcd(hr));
    wr(4'd4, 8'(dw));
    wr(4'd5, bcd(dt));
    wr(4'd6, {2'(c), 1'b0, mb[4:0]});
    wr(4'd7, bcd(yr));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cv[6] = '{0, 0, 0, 1, 2, 3};
    int yv[6] = '{24, 23, 0, 0, 99, 99};
    rst_n = 1'b0; line = 1'b0; hold = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset contents, R1 select default, R10/R11 outputs off
    chk("R12 reset regs", usr, 64'h00_01_81_01_00_00_00_00);
    chk("R10 sqw off at reset", {63'b0, sqw}, 64'd0);
    chk("R11 od off at reset", {63'b0, sqw_od}, 64'd0);

    // R1 60-edge second
    pulses(59);
    chk("R1 no tick after 59 edges", {56'b0, rb(1)}, 64'h00);
    pulses(1);
    chk("R1 tick on edge 60", {56'b0, rb(1)}, 64'h01);

    // R1 50-edge second (select=0, date 01)
    wr(4'd5, 8'h01);
    pulses(49);
    chk("R1 no tick after 49 edges", {56'b0, rb(1)}, 64'h01);
    pulses(1);
    chk("R1 tick on edge 50", {56'b0, rb(1)}, 64'h02);

    // R2/R3 midnight with weekday 7
    set_time(0, 24, 6, 15, 7, 23, 59, 59);
    pulses(50);
    chk("R2 midnight h:m:s", {40'b0, rb(3), rb(2), rb(1)}, 64'h00_00_00);
    chk("R3 weekday 7 wraps to 1", {56'b0, rb(4)}, 64'h01);
    chk("R4 mid-month date step", {56'b0, rb(5)}, 64'h16);

    // R2 BCD minute digit carry
    set_time(0, 24, 6, 15, 3, 12, 9, 59);
    pulses(50);
    chk("R2 minute 09 to 10", {40'b0, rb(3), rb(2), rb(1)}, 64'h12_10_00);

    // R2/R3 hour carry, weekday unchanged
    set_time(0, 24, 6, 15, 3, 12, 59, 59);
    pulses(50);
    chk("R2 hour 12 to 13", {40'b0, rb(3), rb(2), rb(1)}, 64'h13_00_00);
    chk("R3 weekday held off midnight", {56'b0, rb(4)}, 64'h03);

    // R4/R5/R6 month-end sweep
    for (int v = 0; v < 6; v++) begin
      for (int m = 1; m <= 12; m++) begin
        int c, y, last, em, ey, ec;
        string tag;
        c = cv[v]; y = yv[v];
        last = dim(m, y, c);
        tag = (m == 2) ? "R5" : ((m == 12) ? "R6" : "R4");
        em = (m == 12) ? 1 : m + 1;
        ey = (m == 12) ? (y + 1) % 100 : y;
        ec = (m == 12 && y == 99) ? (c + 1) % 4 : c;
        set_time(c, y, m, last, 2, 23, 59, 59);
        pulses(50);
        chk({tag, " last day rolls over"}, {40'b0, rb(7), rb(6), rb(5)},
            {40'b0, bcd(ey), 2'(ec), 1'b0, bcd(em)[4:0], 8'h01});
        set_time(c, y, m, last - 1, 2, 23, 59, 59);
        pulses(50);
        chk({tag, " day before last advances"}, {40'b0, rb(7), rb(6), rb(5)},
            {40'b0, bcd(y), 2'(c), 1'b0, bcd(m)[4:0], bcd(last)});
      end
    end

    // R7 halt bit
    wr(4'd1, 8'h90);
    pulses(60);
    chk("R7 halted seconds frozen", {56'b0, rb(1)}, 64'h90);
    wr(4'd1, 8'h10);
    pulses(50);
    chk("R7 resumes after clear", {56'b0, rb(1)}, 64'h11);

    // R8 write to address 0 restarts prescaler
    pulses(30);
    wr(4'd0, 8'h00);
    pulses(49);
    chk("R8 no tick 49 edges after write", {56'b0, rb(1)}, 64'h11);
    chk("R8 address 0 reads zero", {56'b0, rb(0)}, 64'h00);
    pulses(1);
    chk("R8 tick 50 edges after write", {56'b0, rb(1)}, 64'h12);

    // R9 hold freezes user copy while counting continues
    @(negedge clk); hold = 1'b1;
    pulses(50);
    chk("R9 user copy frozen", {56'b0, rb(1)}, 64'h12);
    @(negedge clk); hold = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 internal kept counting", {56'b0, rb(1)}, 64'h13);

    // R10 square wave
    wr(4'hA, 8'h40);
    wr(4'd1, 8'h00);
    repeat (3) @(negedge clk);
    chk("R10 high at second start", {63'b0, sqw}, 64'd1);
    pulses(24);
    chk("R10 high before half", {63'b0, sqw}, 64'd1);
    pulses(1);
    chk("R10 low at half", {63'b0, sqw}, 64'd0);
    pulses(24);
    chk("R10 low late in second", {63'b0, sqw}, 64'd0);
    pulses(1);
    chk("R10 high at next second", {63'b0, sqw}, 64'd1);
    wr(4'hA, 8'hBF);
    repeat (3) @(negedge clk);
    chk("R10 disabled forces low", {63'b0, sqw}, 64'd0);

    // R11 open-drain select
    wr(4'hC, 8'h40);
    repeat (2) @(negedge clk);
    chk("R11 od set", {63'b0, sqw_od}, 64'd1);
    wr(4'hC, 8'hBF);
    repeat (2) @(negedge clk);
    chk("R11 od cleared by bit 6", {63'b0, sqw_od}, 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule